// File: doc/BRIEF.md
# External Multiplexed Bus Controller

This block turns single memory requests from an internal requester into read and write cycles on an external bus. The bus carries the address and the data on the same lines at different times. The requester presents an address, write data, a flag that asks for a byte or a 16-bit word, and a flag that marks an instruction fetch. The block then runs a fixed sequence on the pins. It first puts the address out with an address strobe, then drives a read or write strobe, and last holds the data. When the transfer is over, it returns a completion pulse together with any read data.

Each cycle on the pins is 8 or 16 bits wide. When dynamic width is enabled, the width is taken from a pin sampled in the address phase of each cycle. When it is disabled, every cycle is 8 bits wide. A word request that lands on an 8-bit cycle is carried out as two byte cycles, the even (low) byte first. Configuration inputs select the style of the address strobe and the style of the write strobes. Slow devices stretch a cycle by holding the ready input low. An external master can take the bus through a hold handshake, and the block signals a bus request while it has work waiting during a hold.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, the following outputs are inactive: read, write and bank pins are high, instruction-fetch, hold-acknowledge and bus-request are low, the bus is not driven, and the requester side is ready.
- R2: A zero-wait read runs one address phase, one clock with the read strobe low and one data phase, then pulses rsp_valid. A word read returns the even-address byte in rsp_rdata[7:0] and the odd-address byte in [15:8].
- R3: Each clock in which ready_i is sampled low while a strobe is active adds one clock of strobe. ready_i has no effect on any pin while no external cycle is running.
- R4: With cfg_wide_en=1, width_i sampled in the address phase selects a 16-bit cycle (1) or an 8-bit cycle (0). With cfg_wide_en=0, every cycle is 8 bits and width_i is ignored.
- R5: A word request on an 8-bit cycle becomes two byte cycles. The first is at the even address and the second at the odd address. On an 8-bit cycle, data moves on ad[7:0] only.
- R6: bhe_n is active low and selects the high byte bank. The encodings are: low byte only = addr bit 0 is 0 with bhe_n 1; high byte only = bit 0 is 1 with bhe_n 0; both bytes = bit 0 is 0 with bhe_n 0. A byte read at an odd address on a 16-bit cycle is taken from ad_in[15:8].
- R7: With cfg_split_wr=0, wr_n goes low on every external write, and bhe_n acts as the bank enable. The read and write strobes are never low together.
- R8: With cfg_split_wr=1, wr_n is the low-byte write strobe and goes low only when an even byte is written. bhe_n is the high-byte write strobe and goes low only when an odd location is written. A word on a 16-bit cycle asserts both.
- R9: With cfg_adv_mode=0, as_o is high only in the address phase. With cfg_adv_mode=1, as_o is low from the address phase through the strobe and returns high in the data phase. In both modes the strobes move only during external cycles.
- R10: inst_o is high for the whole of an external instruction-fetch read, low for a data read, and never high while wr_n is low.
- R11: When hold_i is high, the running cycle completes first. Then hlda_o rises, ad_oe drops, and rd_n, wr_n, bhe_n, inst_o and as_o stay inactive until hold_i falls.
- R12: breq_o is high only while hlda_o is high and a request is pending. It falls when the bus is regained.
- R13: Write data appears on the bus from the strobe phase through the data phase. A byte being written is placed on both byte lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, one bus phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide_en | input | 1 | 1: bus width chosen per cycle by width_i |
| cfg_adv_mode | input | 1 | 1: address-valid strobe style, 0: latch-enable style |
| cfg_split_wr | input | 1 | 1: split low/high byte write strobes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1: 16-bit access, 0: byte access |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | W | Byte address |
| req_wdata | input | W | Write data, byte in [7:0] |
| rsp_valid | output | 1 | Request completed (one cycle pulse) |
| rsp_rdata | output | W | Read data, byte in [7:0] |
| ad_out | output | W | Multiplexed address/data out |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | W | Multiplexed data in |
| as_o | output | 1 | Address strobe (latch-enable or address-valid) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write or low-byte write strobe, active low |
| bhe_n | output | 1 | Bank-high enable or high-byte write strobe, active low |
| inst_o | output | 1 | Instruction-fetch indicator |
| ready_i | input | 1 | Low inserts wait states |
| width_i | input | 1 | 1: 16-bit cycle requested |
| hold_i | input | 1 | External bus hold request |
| hlda_o | output | 1 | Hold acknowledge |
| breq_o | output | 1 | Bus request during hold |

## Verification
The checker watches several properties on every clock:
- pins stay quiet during hold;
- bus-request is never seen without hold-acknowledge;
- a read strobe seen with ready low is still low one clock later;
- hold-acknowledge rises only after the strobes have gone high;
- the read and write strobes are never low together;
- instruction-fetch never appears with a write strobe.

Other behaviour only the bench scenarios can show, because it needs an external memory model and a reference copy of memory:
- correct bytes in the correct lanes;
- the number of cycles a word splits into;
- exact strobe lengths under wait states;
- width_i being ignored when dynamic width is off;
- a cycle caught by hold running to completion.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STRB,
    PH_WAIT,
    PH_DATA,
    PH_HOLD
  } xbus_phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        more,
  input  logic        ready_i,
  input  logic        hold_i,
  output xbus_phase_e phase,
  output logic        wid_en,
  output logic        cap_en,
  output logic        done
);
  xbus_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (hold_i)    phase_d = PH_HOLD;
        else if (busy) phase_d = PH_ADDR;
      end
      PH_ADDR: phase_d = PH_STRB;
      PH_STRB, PH_WAIT: phase_d = ready_i ? PH_DATA : PH_WAIT;
      PH_DATA: begin
        if (hold_i)    phase_d = PH_HOLD;
        else if (more) phase_d = PH_ADDR;
        else           phase_d = PH_IDLE;
      end
      PH_HOLD: begin
        if (!hold_i)   phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase  = phase_q;
  assign wid_en = (phase_q == PH_ADDR);
  assign cap_en = ((phase_q == PH_STRB) || (phase_q == PH_WAIT)) && ready_i;
  assign done   = (phase_q == PH_DATA);
endmodule

// File: rtl/xbus_req.sv
module xbus_req #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic         req_word,
  input  logic         req_fetch,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         req_ready,
  input  logic         wid_en,
  input  logic         cap_en,
  input  logic         done,
  input  logic         wide_en,
  input  logic         width_i,
  input  logic [W-1:0] ad_in,
  output logic         busy,
  output logic         more,
  output logic         r_write,
  output logic         r_fetch,
  output logic         r_w16,
  output logic         both,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] wd,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata
);
  localparam int B = W / 2;

  logic         busy_q, busy_d, write_q, write_d, word_q, word_d;
  logic         fetch_q, fetch_d, half_q, half_d, w16_q, w16_d, rsp_q, rsp_d;
  logic [W-1:0] addr_q, addr_d, wdata_q, wdata_d, rdata_q, rdata_d;
  logic [B-1:0] lane_b, cur_b;
  logic         accept;

  assign accept   = req_valid && !busy_q;
  assign more     = word_q && !w16_q && !half_q;
  assign cur_addr = half_q ? {addr_q[W-1:1], 1'b1} : addr_q;
  assign both     = word_q && !half_q;
  assign lane_b   = (w16_q && cur_addr[0]) ? ad_in[W-1:B] : ad_in[B-1:0];
  assign cur_b    = half_q ? wdata_q[W-1:B] : wdata_q[B-1:0];
  assign wd       = (both && w16_q) ? wdata_q : {cur_b, cur_b};

  always_comb begin
    busy_d  = busy_q;
    write_d = write_q;
    word_d  = word_q;
    fetch_d = fetch_q;
    half_d  = half_q;
    w16_d   = w16_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    rsp_d   = 1'b0;
    if (accept) begin
      busy_d  = 1'b1;
      write_d = req_write;
      word_d  = req_word;
      fetch_d = req_fetch && !req_write;
      half_d  = 1'b0;
      addr_d  = req_word ? {req_addr[W-1:1], 1'b0} : req_addr;
      wdata_d = req_wdata;
    end
    if (wid_en) w16_d = wide_en && width_i;
    if (cap_en && !write_q) begin
      if (word_q && w16_q && !half_q) rdata_d = ad_in;
      else if (word_q && half_q)      rdata_d[W-1:B] = lane_b;
      else if (word_q)                rdata_d[B-1:0] = lane_b;
      else                            rdata_d = {{B{1'b0}}, lane_b};
    end
    if (done) begin
      if (more) begin
        half_d = 1'b1;
      end else begin
        busy_d = 1'b0;
        half_d = 1'b0;
        rsp_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      fetch_q <= 1'b0;
      half_q  <= 1'b0;
      w16_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      write_q <= write_d;
      word_q  <= word_d;
      fetch_q <= fetch_d;
      half_q  <= half_d;
      w16_q   <= w16_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      rsp_q   <= rsp_d;
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign r_write   = write_q;
  assign r_fetch   = fetch_q;
  assign r_w16     = w16_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int W = 16
) (
  input  xbus_phase_e  phase,
  input  logic         cfg_adv_mode,
  input  logic         cfg_split_wr,
  input  logic         r_write,
  input  logic         r_fetch,
  input  logic         r_w16,
  input  logic         both,
  input  logic [W-1:0] cur_addr,
  input  logic [W-1:0] wd,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         as_o,
  output logic         rd_n,
  output logic         wr_n,
  output logic         bhe_n,
  output logic         inst_o
);
  logic act, strb, early, hi_sel, wr_lo, wr_hi;

  assign early  = (phase == PH_ADDR) || (phase == PH_STRB) || (phase == PH_WAIT);
  assign act    = early || (phase == PH_DATA);
  assign strb   = (phase == PH_STRB) || (phase == PH_WAIT);
  assign hi_sel = both || cur_addr[0];
  assign wr_lo  = (both && r_w16) || !cur_addr[0];
  assign wr_hi  = (both && r_w16) || cur_addr[0];

  always_comb begin
    ad_oe  = (phase == PH_ADDR) || (r_write && act);
    ad_out = (phase == PH_ADDR) ? cur_addr : (r_write ? wd : '0);
    as_o   = cfg_adv_mode ? !early : (phase == PH_ADDR);
    rd_n   = !(strb && !r_write);
    inst_o = act && r_fetch && !r_write;
    if (cfg_split_wr) begin
      wr_n  = !(strb && r_write && wr_lo);
      bhe_n = !(strb && r_write && wr_hi);
    end else begin
      wr_n  = !(strb && r_write);
      bhe_n = !(act && hi_sel);
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wide_en,
  input  logic         cfg_adv_mode,
  input  logic         cfg_split_wr,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic         req_word,
  input  logic         req_fetch,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  input  logic [W-1:0] ad_in,
  output logic         as_o,
  output logic         rd_n,
  output logic         wr_n,
  output logic         bhe_n,
  output logic         inst_o,
  input  logic         ready_i,
  input  logic         width_i,
  input  logic         hold_i,
  output logic         hlda_o,
  output logic         breq_o
);
  logic [1:0]   rst_sync;
  logic         srst_n;
  xbus_phase_e  phase;
  logic         busy, more, wid_en, cap_en, done;
  logic         r_write, r_fetch, r_w16, both;
  logic [W-1:0] cur_addr, wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  xbus_seq u_seq (
    .clk(clk), .rst_n(srst_n), .busy(busy), .more(more), .ready_i(ready_i),
    .hold_i(hold_i), .phase(phase), .wid_en(wid_en), .cap_en(cap_en), .done(done)
  );

  xbus_req #(.W(W)) u_req (
    .clk(clk), .rst_n(srst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_fetch(req_fetch), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .wid_en(wid_en),
    .cap_en(cap_en), .done(done), .wide_en(cfg_wide_en), .width_i(width_i),
    .ad_in(ad_in), .busy(busy), .more(more), .r_write(r_write),
    .r_fetch(r_fetch), .r_w16(r_w16), .both(both), .cur_addr(cur_addr),
    .wd(wd), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  xbus_pins #(.W(W)) u_pins (
    .phase(phase), .cfg_adv_mode(cfg_adv_mode), .cfg_split_wr(cfg_split_wr),
    .r_write(r_write), .r_fetch(r_fetch), .r_w16(r_w16), .both(both),
    .cur_addr(cur_addr), .wd(wd), .ad_out(ad_out), .ad_oe(ad_oe),
    .as_o(as_o), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .inst_o(inst_o)
  );

  assign hlda_o = (phase == PH_HOLD);
  assign breq_o = hlda_o && busy;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_adv_mode,
  input logic ad_oe,
  input logic as_o,
  input logic rd_n,
  input logic wr_n,
  input logic bhe_n,
  input logic inst_o,
  input logic ready_i,
  input logic hlda_o,
  input logic breq_o
);
  assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> (rd_n && wr_n && bhe_n && !inst_o && !ad_oe));

  assert_hold_after_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_o) |-> ($past(rd_n) && $past(wr_n)));

  assert_breq_in_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    breq_o |-> hlda_o);

  assert_wait_stretch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !ready_i) |=> !rd_n);

  assert_rw_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_fetch_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inst_o |-> wr_n);

  assert_ale_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_mode && as_o) |-> (ad_oe && rd_n && wr_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_adv_mode(cfg_adv_mode), .ad_oe(ad_oe),
  .as_o(as_o), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .inst_o(inst_o),
  .ready_i(ready_i), .hlda_o(hlda_o), .breq_o(breq_o)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_wide_en, cfg_adv_mode, cfg_split_wr;
  logic req_valid, req_ready, req_write, req_word, req_fetch;
  logic [W-1:0] req_addr, req_wdata, rsp_rdata, ad_out, ad_in;
  logic rsp_valid, ad_oe, as_o, rd_n, wr_n, bhe_n, inst_o;
  logic ready_i, width_i, hold_i, hlda_o, breq_o;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] lat;
  logic wig_en, wig, width_force;
  int wait_cfg, wcnt, ncyc, slen, tot_as, tot_strobe, checks, errors;
  bit inst_bad, prev_as, prev_wr, prev_bhe, finished;

  typedef struct {
    bit rd; logic [15:0] exp; int cyc; int slen; bit fetch; string tag;
  } item_t;
  item_t q[$];

  xbus_ctrl #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide_en(cfg_wide_en), .cfg_adv_mode(cfg_adv_mode),
    .cfg_split_wr(cfg_split_wr), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_fetch(req_fetch),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .as_o(as_o), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .inst_o(inst_o),
    .ready_i(ready_i), .width_i(width_i), .hold_i(hold_i), .hlda_o(hlda_o),
    .breq_o(breq_o)
  );

  // external memory: addresses with bit 7 set form an 8-bit region
  assign ad_in   = !rd_n ? (lat[7] ? {mem[lat], mem[lat]}
                                   : {mem[{lat[7:1], 1'b1}], mem[{lat[7:1], 1'b0}]}) : '0;
  assign ready_i = wig_en ? wig : (wcnt > wait_cfg);
  assign width_i = wig_en ? ~wig : (width_force ? 1'b1 : ~ad_out[7]);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus model and scoreboard monitor
  always @(negedge clk) begin
    bit strobe, wide;
    if (cfg_adv_mode ? (!as_o && prev_as) : as_o) begin
      lat = ad_out[7:0]; ncyc++; tot_as++;
    end
    prev_as = as_o;
    strobe = !rd_n || !wr_n || (cfg_split_wr && !bhe_n);
    if (strobe) begin
      wcnt++; slen++; tot_strobe++;
      if (q.size() != 0 && inst_o != q[0].fetch) inst_bad = 1;
    end else wcnt = 0;
    wide = !lat[7];
    if (!cfg_split_wr) begin
      if (!prev_wr && wr_n) begin
        if (!wide) mem[lat] = ad_out[7:0];
        else begin
          if (!lat[0]) mem[lat] = ad_out[7:0];
          if (!bhe_n) mem[{lat[7:1], 1'b1}] = ad_out[15:8];
        end
      end
    end else begin
      if (!prev_wr && wr_n) begin
        if (wide) mem[{lat[7:1], 1'b0}] = ad_out[7:0]; else mem[lat] = ad_out[7:0];
      end
      if (!prev_bhe && bhe_n) begin
        if (wide) mem[{lat[7:1], 1'b1}] = ad_out[15:8]; else mem[lat] = ad_out[7:0];
      end
    end
    prev_wr = wr_n;
    prev_bhe = bhe_n;
    if (rsp_valid) begin
      if (q.size() == 0) chk(0, "R2", "unexpected completion", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        if (it.rd) chk(rsp_rdata == it.exp, it.tag, "read data", rsp_rdata, it.exp);
        chk(ncyc == it.cyc, it.tag, "bus cycle count", ncyc, it.cyc);
        chk(slen == it.slen, it.tag, "strobe clocks", slen, it.slen);
        chk(!inst_bad, it.tag, "inst_o during strobe", inst_bad, 0);
      end
      ncyc = 0; slen = 0; inst_bad = 0;
    end
  end

  task automatic push_item(input bit wr, input bit word, input bit fetch,
                           input logic [7:0] addr, input logic [15:0] data,
                           input int waits, input string tag);
    item_t it;
    logic [7:0] a;
    bit wide;
    a = addr;
    if (word) a[0] = 1'b0;
    wide = cfg_wide_en && (width_force || !a[7]);
    it.rd = !wr;
    it.cyc = (word && !wide) ? 2 : 1;
    it.slen = it.cyc * (waits + 1);
    it.fetch = fetch && !wr;
    it.tag = tag;
    it.exp = '0;
    if (!wr) it.exp = word ? {ref_mem[a | 8'h01], ref_mem[a]} : {8'h00, ref_mem[a]};
    else if (word) begin
      ref_mem[a] = data[7:0]; ref_mem[a | 8'h01] = data[15:8];
    end else ref_mem[a] = data[7:0];
    wait_cfg = waits;
    q.push_back(it);
  endtask

  task automatic drive_req(input bit wr, input bit word, input bit fetch,
                           input logic [7:0] addr, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = word; req_fetch = fetch;
    req_addr = {8'h00, addr}; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit wr, input bit word, input bit fetch,
                     input logic [7:0] addr, input logic [15:0] data,
                     input int waits, input string tag);
    push_item(wr, word, fetch, addr, data, waits, tag);
    drive_req(wr, word, fetch, addr, data);
    wait_done();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int as0, st0;
    rst_n = 0; req_valid = 0; req_write = 0; req_word = 0; req_fetch = 0;
    req_addr = '0; req_wdata = '0; hold_i = 0; wig_en = 0; wig = 0; width_force = 0;
    wait_cfg = 0; cfg_wide_en = 1; cfg_adv_mode = 0; cfg_split_wr = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rd_n && wr_n && bhe_n, "R1", "strobes idle", {rd_n, wr_n, bhe_n}, 3'b111);
    chk(!as_o && !inst_o && !hlda_o && !breq_o, "R1", "outputs low",
        {as_o, inst_o, hlda_o, breq_o}, 0);
    chk(!ad_oe && req_ready, "R1", "bus undriven, ready", {ad_oe, req_ready}, 1);

    run(0, 1, 0, 8'h10, 0, 0, "R2/R4/R6 word read 16-bit");
    run(0, 0, 0, 8'h13, 0, 0, "R6 odd byte read upper lane");
    run(0, 1, 0, 8'h90, 0, 0, "R5 word read split on 8-bit");
    run(0, 1, 0, 8'h18, 0, 2, "R3 two wait states");
    run(0, 0, 0, 8'h95, 0, 3, "R3/R5 byte read 8-bit waits");
    run(0, 1, 1, 8'h20, 0, 0, "R10 instruction fetch");
    run(0, 0, 0, 8'h21, 0, 0, "R10 data read");
    // R7 combined write strobe, R13 lane placement
    run(1, 0, 0, 8'h15, 16'h00A5, 0, "R7/R13 odd byte write");
    run(1, 1, 0, 8'h30, 16'h1234, 1, "R7 word write");
    run(0, 1, 0, 8'h14, 0, 0, "R7 readback");
    run(0, 1, 0, 8'h30, 0, 0, "R7 readback word");
    // R8 split strobes
    cfg_split_wr = 1;
    run(1, 0, 0, 8'h40, 16'h005A, 0, "R8 even byte write");
    run(1, 0, 0, 8'h43, 16'h00C3, 0, "R8 odd byte write");
    run(1, 1, 0, 8'h50, 16'hBEEF, 0, "R8 word write 16-bit");
    run(1, 1, 0, 8'h94, 16'h7788, 0, "R8/R5 word write 8-bit");
    cfg_split_wr = 0;
    run(0, 1, 0, 8'h40, 0, 0, "R8 readback even");
    run(0, 1, 0, 8'h42, 0, 0, "R8 readback odd");
    run(0, 1, 0, 8'h50, 0, 0, "R8 readback word");
    run(0, 1, 0, 8'h94, 0, 0, "R8 readback 8-bit");
    // R4 width ignored when dynamic width is off
    cfg_wide_en = 0; width_force = 1;
    run(0, 1, 0, 8'h98, 0, 0, "R4 width_i ignored");
    width_force = 0; cfg_wide_en = 1;
    // R9 address-valid mode
    cfg_adv_mode = 1;
    @(negedge clk);
    chk(as_o == 1'b1, "R9", "address-valid idle high", as_o, 1);
    run(0, 1, 0, 8'h92, 0, 0, "R9 adv split word");
    run(0, 1, 0, 8'h16, 0, 1, "R9 adv word read");
    // R3/R9 inputs wiggle while idle
    as0 = tot_as; st0 = tot_strobe;
    wig_en = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); wig = ~wig; end
    wig_en = 0;
    @(negedge clk);
    chk(tot_as == as0 && tot_strobe == st0, "R3", "idle ready no effect",
        tot_strobe - st0, 0);
    chk(rd_n && wr_n && as_o, "R9", "idle pins steady", {rd_n, wr_n, as_o}, 3'b111);
    // R11/R12 hold while idle
    hold_i = 1;
    repeat (3) @(negedge clk);
    chk(hlda_o && !ad_oe, "R11", "hold ack and float", {hlda_o, ad_oe}, 2'b10);
    chk(rd_n && wr_n && bhe_n && !inst_o && as_o, "R11", "pins inactive in hold",
        {rd_n, wr_n, bhe_n, inst_o, as_o}, 5'b11101);
    chk(!breq_o, "R12", "no request no breq", breq_o, 0);
    push_item(0, 1, 0, 8'h12, 0, 0, "R12 access after hold");
    drive_req(0, 1, 0, 8'h12, 0);
    repeat (2) @(negedge clk);
    chk(breq_o, "R12", "breq with pending access", breq_o, 1);
    chk(ncyc == 0, "R11", "no cycle during hold", ncyc, 0);
    hold_i = 0;
    wait_done();
    chk(!breq_o && !hlda_o, "R12", "breq released", {breq_o, hlda_o}, 0);
    // R11 hold during a running cycle
    cfg_adv_mode = 0;
    push_item(0, 0, 0, 8'h17, 0, 3, "R11 cycle completes");
    drive_req(0, 0, 0, 8'h17, 0);
    while (rd_n) @(negedge clk);
    hold_i = 1;
    while (q.size() != 0) @(negedge clk);
    chk(hlda_o, "R11", "hold after completion", hlda_o, 1);
    hold_i = 0;
    repeat (3) @(negedge clk);
    chk(!hlda_o, "R11", "bus regained", hlda_o, 0);
    finish_run();
  end
endmodule